// File: doc/BRIEF.md
# Scattered Bitfield Register Writer

This block takes one wide value and distributes it, least significant bit first, over bit ranges that sit in several narrow registers. An internal descriptor table, filled beforehand through a small write port, lists the targets in order: each slot names a register and a low and a high bit position. A start strobe supplies the value and the slot where the list begins. For each listed target the block reads the register, replaces the chosen range with the next unused value bits, and writes the byte back, so bits outside every range keep their contents.

A slot whose register field is all ones ends the list. A list with no such slot stops after every table slot has been used once. On completion the block raises `done` and presents `capacity`, two raised to the total number of bits placed, so a caller can compare a value against the range the list can hold.

Top module: `scatter_writer`

## Requirements
- R1: After synchronous reset `done`, `reg_re` and `reg_we` are 0 and `capacity` is 0.
- R2: A slot with register field 15 (all ones) ends the list; if the start slot holds it, `done` is 1 in the cycle after the start edge and no register read or write occurs.
- R3: Each listed target is read with `reg_re` high and `reg_addr` set to its register; read data is taken in the cycle after `reg_re`; the merged byte is written with `reg_we` high two cycles after `reg_re` at the same address, and read and write are never high together. Each entry takes 3 cycles, so `done` is 1 at 3·N+1 cycles after the start edge for N entries.
- R4: Within one target, register bits low..high ascending receive consecutive value bits starting at the lowest not yet used; every other register bit is written back unchanged.
- R5: Value bits are consumed across entries in list order; the next entry starts with the value bit that follows the last bit placed by the previous entry.
- R6: When `done` rises, `capacity` equals 2 to the power of the sum over all entries of (high − low + 1), and is held until the next list completes.
- R7: A list with no terminator stops after 8 entries (the table depth).
- R8: A start pulse while a list is being processed is ignored; `done` stays high until the next accepted start, which clears it at the following edge.
- R9: Processing begins at table slot `start_slot` and proceeds to consecutive slots, wrapping from slot 7 to slot 0.
- R10: An entry whose high bit is below its low bit is still read and written back, with no bit changed and no value bits consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Write one descriptor slot |
| tbl_slot | input | 3 | Slot written |
| tbl_reg | input | 4 | Register number of the slot (15 = end of list) |
| tbl_lo | input | 3 | Low bit position of the slot |
| tbl_hi | input | 3 | High bit position of the slot |
| start | input | 1 | Begin a list (taken only when idle) |
| start_value | input | 32 | Value to spread |
| start_slot | input | 3 | First slot of the list |
| reg_re | output | 1 | Register read strobe |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | 4 | Register number for read or write |
| reg_wdata | output | 8 | Byte written |
| reg_rdata | input | 8 | Byte read, valid the cycle after `reg_re` |
| done | output | 1 | List completed |
| capacity | output | 65 | Two to the power of the bits placed |

## Verification
A wrong position pointer or value shift shows up as a wrong byte on `reg_wdata` at the first write after the fault, three cycles into the affected entry, and is caught when the register image is compared after `done`. A broken terminator or entry counter shows as an extra or missing access and a `done` that arrives at the wrong cycle, measured against 3·N+1. A wrong bit total shows on `capacity` in the very cycle `done` rises.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DECODE,
    ST_WAIT,
    ST_MERGE
  } sbw_state_t;
endpackage

// File: rtl/desc_table.sv
// Descriptor storage: one write port, registered read (block RAM friendly).
module desc_table #(
  parameter int DEPTH = 8,
  parameter int EW    = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rdata
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/field_merge.sv
// Places the low bits of src into old_byte[hi:lo]; reports the field width.
module field_merge #(
  parameter int REG_W = 8,
  localparam int BIT_W = $clog2(REG_W)
) (
  input  logic [REG_W-1:0] old_byte,
  input  logic [BIT_W-1:0] lo,
  input  logic [BIT_W-1:0] hi,
  input  logic [REG_W-1:0] src,
  output logic [REG_W-1:0] merged,
  output logic [BIT_W:0]   width
);
  logic [REG_W-1:0] placed;
  logic [REG_W-1:0] in_rng;

  assign placed = src << lo;

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    assign in_rng[b] = ({1'b0, lo} <= (BIT_W+1)'(b)) && ((BIT_W+1)'(b) <= {1'b0, hi});
    assign merged[b] = in_rng[b] ? placed[b] : old_byte[b];
  end

  assign width = (hi >= lo) ? ({1'b0, hi} - {1'b0, lo} + 1'b1) : '0;
endmodule

// File: rtl/scatter_writer.sv
module scatter_writer
  import sbw_pkg::*;
#(
  parameter int VAL_W = 32,
  parameter int REG_W = 8,
  parameter int IDX_W = 4,
  parameter int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int BIT_W = $clog2(REG_W),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int TB_W  = $clog2(DEPTH * REG_W + 1),
  localparam int CAP_W = DEPTH * REG_W + 1,
  localparam int EW    = IDX_W + 2 * BIT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tbl_we,
  input  logic [AW-1:0]    tbl_slot,
  input  logic [IDX_W-1:0] tbl_reg,
  input  logic [BIT_W-1:0] tbl_lo,
  input  logic [BIT_W-1:0] tbl_hi,
  input  logic             start,
  input  logic [VAL_W-1:0] start_value,
  input  logic [AW-1:0]    start_slot,
  output logic             reg_re,
  output logic             reg_we,
  output logic [IDX_W-1:0] reg_addr,
  output logic [REG_W-1:0] reg_wdata,
  input  logic [REG_W-1:0] reg_rdata,
  output logic             done,
  output logic [CAP_W-1:0] capacity
);
  localparam logic [IDX_W-1:0] END_IDX = {IDX_W{1'b1}};

  sbw_state_t       state;
  logic [AW-1:0]    ptr;
  logic [AW-1:0]    rd_slot;
  logic [CNT_W-1:0] cnt;
  logic [TB_W-1:0]  total;
  logic [VAL_W-1:0] val_q;
  logic [EW-1:0]    entry;
  logic [IDX_W-1:0] e_idx;
  logic [BIT_W-1:0] e_lo, e_hi;
  logic [REG_W-1:0] merged;
  logic [BIT_W:0]   width;
  logic             list_end;

  // Read address chosen so the next slot is already registered on entering DECODE.
  always_comb begin
    case (state)
      ST_IDLE:  rd_slot = start_slot;
      ST_MERGE: rd_slot = AW'(ptr + 1'b1);
      default:  rd_slot = ptr;
    endcase
  end

  desc_table #(.DEPTH(DEPTH), .EW(EW)) u_tbl (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_slot),
    .wdata ({tbl_reg, tbl_lo, tbl_hi}),
    .raddr (rd_slot),
    .rdata (entry)
  );

  assign {e_idx, e_lo, e_hi} = entry;
  assign list_end = (e_idx == END_IDX) || (cnt == CNT_W'(DEPTH));

  field_merge #(.REG_W(REG_W)) u_merge (
    .old_byte (reg_rdata),
    .lo       (e_lo),
    .hi       (e_hi),
    .src      (val_q[REG_W-1:0]),
    .merged   (merged),
    .width    (width)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ptr       <= '0;
      cnt       <= '0;
      total     <= '0;
      val_q     <= '0;
      reg_re    <= 1'b0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      done      <= 1'b0;
      capacity  <= '0;
    end else begin
      reg_re <= 1'b0;
      reg_we <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            ptr   <= start_slot;
            val_q <= start_value;
            cnt   <= '0;
            total <= '0;
            done  <= 1'b0;
            state <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          if (list_end) begin
            done     <= 1'b1;
            capacity <= CAP_W'(1) << total;
            state    <= ST_IDLE;
          end else begin
            reg_re   <= 1'b1;
            reg_addr <= e_idx;
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: state <= ST_MERGE;
        ST_MERGE: begin
          reg_we    <= 1'b1;
          reg_wdata <= merged;
          val_q     <= val_q >> width;
          total     <= total + TB_W'(width);
          cnt       <= cnt + 1'b1;
          ptr       <= AW'(ptr + 1'b1);
          state     <= ST_DECODE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scatter_writer_chk.sv
module scatter_writer_chk #(
  parameter int IDX_W = 4,
  parameter int CAP_W = 65
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_re,
  input logic             reg_we,
  input logic [IDX_W-1:0] reg_addr,
  input logic             done,
  input logic [CAP_W-1:0] capacity
);
  assert_rw_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(reg_re && reg_we));

  assert_write_after_read_R3: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> $past(reg_re, 2));

  assert_write_same_addr_R3: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (reg_addr == $past(reg_addr, 2)));

  assert_capacity_pow2_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($countones(capacity) == 1));

  assert_done_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (!reg_re && !reg_we));
endmodule

bind scatter_writer scatter_writer_chk #(.IDX_W(IDX_W), .CAP_W(CAP_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_re   (reg_re),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .done     (done),
  .capacity (capacity)
);

// File: tb/sim_scatter_writer.sv
`timescale 1ns/100ps
module sim_scatter_writer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_slot = '0;
  logic [3:0]  tbl_reg = '0;
  logic [2:0]  tbl_lo = '0, tbl_hi = '0;
  logic        start = 1'b0;
  logic [31:0] start_value = '0;
  logic [2:0]  start_slot = '0;
  logic        reg_re, reg_we, done;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata = '0;
  logic [64:0] capacity;

  int checks = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0;
  bit finished = 0;

  logic [7:0] regs [16];
  logic [7:0] ref_regs [16];
  int s_idx [8], s_lo [8], s_hi [8];

  // Vector table: start slot, value, expected entries, expected bits placed.
  localparam int          V_N = 6;
  localparam int          V_BASE [V_N] = '{0, 4, 3, 6, 7, 0};
  localparam logic [31:0] V_VAL  [V_N] = '{32'h0000_03A5, 32'h0000_01FF, 32'h1234_5678,
                                           32'hFFFF_FFFF, 32'h0000_0ABC, 32'hFFFF_FFFF};
  localparam int          V_ENT  [V_N] = '{3, 2, 0, 0, 4, 3};
  localparam int          V_BITS [V_N] = '{10, 9, 0, 0, 10, 10};

  always #2.5 clk = ~clk;

  scatter_writer u0 (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_slot(tbl_slot), .tbl_reg(tbl_reg),
    .tbl_lo(tbl_lo), .tbl_hi(tbl_hi), .start(start), .start_value(start_value),
    .start_slot(start_slot), .reg_re(reg_re), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done), .capacity(capacity)
  );

  // Register file model: one-cycle read latency.
  initial for (int i = 0; i < 16; i++) regs[i] = 8'h5A ^ 8'(i * 19);
  always @(posedge clk) begin
    if (reg_we) regs[reg_addr] <= reg_wdata;
    if (reg_re) reg_rdata <= regs[reg_addr];
  end

  always @(negedge clk) begin
    if (reg_we) wr_cnt++;
    if (reg_re) rd_cnt++;
  end

  task automatic check(input bit ok, input string what, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic load_desc(input int slot, input int idx, input int lo, input int hi);
    @(negedge clk);
    tbl_we = 1'b1; tbl_slot = 3'(slot); tbl_reg = 4'(idx); tbl_lo = 3'(lo); tbl_hi = 3'(hi);
    s_idx[slot] = idx; s_lo[slot] = lo; s_hi[slot] = hi;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // Reference model built from R4, R5, R7, R9, R10.
  task automatic ref_run(input int base, input logic [31:0] v, output int bits, output int nent);
    logic [31:0] vv;
    int s;
    vv = v; bits = 0; nent = 0;
    for (int k = 0; k < 8; k++) begin
      s = (base + k) % 8;
      if (s_idx[s] == 15) break;
      nent++;
      if (s_hi[s] >= s_lo[s])
        for (int b = s_lo[s]; b <= s_hi[s]; b++) begin
          ref_regs[s_idx[s]][b] = vv[0];
          vv = vv >> 1;
          bits++;
        end
    end
  endtask

  task automatic start_list(input int base, input logic [31:0] v);
    @(negedge clk);
    wr_cnt = 0; rd_cnt = 0;
    start = 1'b1; start_slot = 3'(base); start_value = v;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic compare_regs(input string tag);
    bit ok;
    ok = 1;
    for (int i = 0; i < 16; i++)
      if (regs[i] !== ref_regs[i]) begin
        ok = 0;
        $display("FAIL %s reg %0d actual=%0h expected=%0h", tag, i, regs[i], ref_regs[i]);
      end
    checks++;
    if (!ok) fails++;
  endtask

  task automatic run_and_check(input int base, input logic [31:0] v, input int exp_ent, input int exp_bits);
    int bits, nent, lat;
    ref_run(base, v, bits, nent);
    start_list(base, v);
    check(done == 1'b0, "R8 done cleared by accepted start", 65'(done), 65'd0);
    wait_done(lat);
    check(nent == exp_ent && bits == exp_bits, "R5 R9 reference entry/bit count", 65'(nent), 65'(exp_ent));
    check(lat == 3 * exp_ent + 1, "R3 R2 done latency", 65'(lat), 65'(3 * exp_ent + 1));
    check(wr_cnt == exp_ent && rd_cnt == exp_ent, "R3 R7 access count", 65'(wr_cnt), 65'(exp_ent));
    check(capacity == (65'd1 << exp_bits), "R6 capacity", capacity, 65'd1 << exp_bits);
    compare_regs("R4 R5 R9 R10 register image");
  endtask

  initial begin
    int lat, bits, nent;
    for (int i = 0; i < 16; i++) ref_regs[i] = 8'h5A ^ 8'(i * 19);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done == 0 && reg_re == 0 && reg_we == 0, "R1 reset strobes/done", 65'({done, reg_re, reg_we}), 65'd0);
    check(capacity == 0, "R1 reset capacity", capacity, 65'd0);

    load_desc(0, 2, 0, 3);
    load_desc(1, 5, 4, 7);
    load_desc(2, 2, 6, 7);
    load_desc(3, 15, 0, 0);
    load_desc(4, 7, 2, 2);
    load_desc(5, 1, 0, 7);
    load_desc(6, 15, 0, 0);
    load_desc(7, 3, 5, 3);   // R10: high below low

    for (int k = 0; k < V_N; k++)
      run_and_check(V_BASE[k], V_VAL[k], V_ENT[k], V_BITS[k]);

    // R2: empty list, done one cycle after the start edge, no access.
    start_list(3, 32'hDEAD_BEEF);
    check(done == 1'b0, "R2 empty list done not yet", 65'(done), 65'd0);
    @(negedge clk);
    check(done == 1'b1, "R2 empty list done after one cycle", 65'(done), 65'd1);
    check(rd_cnt == 0 && wr_cnt == 0, "R2 empty list no access", 65'(rd_cnt + wr_cnt), 65'd0);
    check(capacity == 65'd1, "R2 R6 empty capacity", capacity, 65'd1);

    // R8: start pulse while busy is ignored.
    ref_run(0, 32'h0000_0156, bits, nent);
    start_list(0, 32'h0000_0156);
    @(negedge clk);
    start = 1'b1; start_slot = 3'd4; start_value = 32'h0000_00FF;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    check(capacity == 65'd1024, "R8 busy start ignored capacity", capacity, 65'd1024);
    check(wr_cnt == 3, "R8 busy start ignored writes", 65'(wr_cnt), 65'd3);
    compare_regs("R8 busy start ignored register image");
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R8 done held while idle", 65'(done), 65'd1);

    // R7: no terminator, eight entries then stop.
    for (int s = 0; s < 8; s++) load_desc(s, s, 0, 3);
    run_and_check(0, 32'h8765_4321, 8, 32);
    run_and_check(5, 32'h0F1E_2D3C, 8, 32);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R3 actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule